// File: doc/BRIEF.md
# Thread Lifecycle Scheduler

This block sits between a memory-access pipeline and an execution pipeline and moves whole threads, not instructions, through their three phases. A thread arrives once its input count has reached zero, carrying the index of its frame and the address of its first pre-load instruction. The block gives it a register context taken from a circular pool. It queues the thread for pre-load on the memory-access pipeline and then hands it across to the execution pipeline. When execution ends, the thread goes back to the memory-access pipeline for post-store. Each hand-off between the two pipelines passes through a fixed delay line.

Each pipeline is represented by a start pulse, which carries the context and the instruction address, and a done pulse, which returns the address where the next phase begins. Pre-load and post-store share the memory-access pipeline, and post-store is served first. When a post-store finishes, the register context goes back to the pool and a frame-release request carrying the thread's frame index is issued. If every context is in use, new threads wait in a bounded queue in the order they arrived.

Top module: `thr_sched`

## Requirements
- R1: After reset, mp_start_o, ex_start_o and ffree_valid_o are low and thr_ready_o is high.
- R2: Context numbers 0 to NUM_CTX-1 are handed out in ascending order after reset. A released context joins the back of the free ring, so contexts are reused in the order they were freed.
- R3: A thread is accepted in a cycle where thr_valid_i and thr_ready_o are both high. Accepted threads receive contexts and start pre-load in the order they arrived. thr_ready_o goes low once WAIT_DEPTH threads are waiting for a context.
- R4: A pre-load start is a one-cycle mp_start_o with mp_store_o=0, showing the thread's frame index on mp_fp_o and its entry address on mp_ip_o. When a context is free and the memory-access pipeline is idle and has nothing queued, mp_start_o rises two clock edges after the accepting edge.
- R5: The execution start for a thread shows the same context on ex_ctx_o, with ex_ip_o equal to the mp_next_ip_i returned at its pre-load done. If the execution pipeline is idle, ex_start_o rises FORK_LAT+1 edges after the edge that samples that done.
- R6: The post-store start shows mp_store_o=1, the thread's context, and mp_ip_o equal to the ex_next_ip_i returned at its execution done. If the memory-access pipeline is idle, it rises FORK_LAT+1 edges after the edge that samples that done.
- R7: When a post-store and a pre-load are both queued for an idle memory-access pipeline, the post-store starts first.
- R8: Each pipeline serves one thread at a time. A start is a one-cycle pulse, and no new start appears on a pipeline until its done pulse has been taken.
- R9: At the edge that samples a post-store done, ffree_valid_o rises for one cycle with the thread's frame index on ffree_fp_o, and the thread's context returns to the pool.
- R10: While a pipeline is busy, its context, instruction address and phase outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_valid_i | input | 1 | Enabled thread offered |
| thr_fp_i | input | FP_W | Frame index of offered thread |
| thr_ip_i | input | IP_W | Address of its first pre-load instruction |
| thr_ready_o | output | 1 | Waiting queue can take a thread |
| mp_start_o | output | 1 | Memory-access pipeline start pulse |
| mp_store_o | output | 1 | Phase on memory-access pipeline: 0 pre-load, 1 post-store |
| mp_ctx_o | output | CTX_W | Context being served by memory-access pipeline |
| mp_fp_o | output | FP_W | Frame index of that thread |
| mp_ip_o | output | IP_W | Instruction address of the phase |
| mp_done_i | input | 1 | Memory-access phase finished |
| mp_next_ip_i | input | IP_W | Address following the pre-load code |
| ex_start_o | output | 1 | Execution pipeline start pulse |
| ex_ctx_o | output | CTX_W | Context being executed |
| ex_ip_o | output | IP_W | First executable instruction address |
| ex_done_i | input | 1 | Execution finished |
| ex_next_ip_i | input | IP_W | Address of first post-store instruction |
| ffree_valid_o | output | 1 | Frame release request |
| ffree_fp_o | output | FP_W | Frame index to release |

## Verification
Pre-load and post-store work can become ready for the memory-access pipeline at the same moment, and the arbitration between them is the behaviour under test. The bench provokes this with a slow pre-load responder and a fast execution responder, so that a returned thread reaches the post-store list while the next pre-load is still queued. It records the edge at which each execution done is sampled. Any pre-load start that appears at or after FORK_LAT+1 edges past an execution done whose post-store has not yet started is reported as a failure.

// File: rtl/thr_sched_pkg.sv
package thr_sched_pkg;
  typedef enum logic {
    MP_PRELOAD   = 1'b0,
    MP_POSTSTORE = 1'b1
  } mp_kind_e;
endpackage

// File: rtl/thr_fifo.sv
module thr_fifo #(
  parameter int WIDTH   = 4,
  parameter int DEPTH   = 4,
  parameter bit PRELOAD = 1'b0  // reset full, holding 0..DEPTH-1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] RST_CNT = PRELOAD ? CNT_W'(DEPTH) : '0;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign data_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= PRELOAD ? WIDTH'(i) : '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= RST_CNT;
    end else begin
      if (push_i) begin
        mem[wr_ptr] <= data_i;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (pop_i) rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/thr_fork_line.sv
module thr_fork_line #(
  parameter int LAT   = 4,
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [WIDTH-1:0] in_data_i,
  output logic             out_valid_o,
  output logic [WIDTH-1:0] out_data_o
);
  generate
    if (LAT == 0) begin : g_bypass
      assign out_valid_o = in_valid_i;
      assign out_data_o  = in_data_i;
    end else begin : g_pipe
      logic             v_q [LAT];
      logic [WIDTH-1:0] d_q [LAT];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < LAT; i++) begin
            v_q[i] <= 1'b0;
            d_q[i] <= '0;
          end
        end else begin
          v_q[0] <= in_valid_i;
          d_q[0] <= in_data_i;
          for (int i = 1; i < LAT; i++) begin
            v_q[i] <= v_q[i-1];
            d_q[i] <= d_q[i-1];
          end
        end
      end
      assign out_valid_o = v_q[LAT-1];
      assign out_data_o  = d_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/thr_sched.sv
module thr_sched
  import thr_sched_pkg::*;
#(
  parameter int NUM_CTX    = 4,
  parameter int FP_W       = 8,
  parameter int IP_W       = 12,
  parameter int WAIT_DEPTH = 4,
  parameter int FORK_LAT   = 4,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_valid_i,
  input  logic [FP_W-1:0]  thr_fp_i,
  input  logic [IP_W-1:0]  thr_ip_i,
  output logic             thr_ready_o,
  output logic             mp_start_o,
  output logic             mp_store_o,
  output logic [CTX_W-1:0] mp_ctx_o,
  output logic [FP_W-1:0]  mp_fp_o,
  output logic [IP_W-1:0]  mp_ip_o,
  input  logic             mp_done_i,
  input  logic [IP_W-1:0]  mp_next_ip_i,
  output logic             ex_start_o,
  output logic [CTX_W-1:0] ex_ctx_o,
  output logic [IP_W-1:0]  ex_ip_o,
  input  logic             ex_done_i,
  input  logic [IP_W-1:0]  ex_next_ip_i,
  output logic             ffree_valid_o,
  output logic [FP_W-1:0]  ffree_fp_o
);
  localparam int ARR_W = FP_W + IP_W;

  // waiting threads and the free-context ring
  logic [ARR_W-1:0] wait_head;
  logic             wait_empty, wait_full, wait_push;
  logic [CTX_W-1:0] pool_head;
  logic             pool_empty, pool_full;
  // per-phase lists hold context numbers only
  logic [CTX_W-1:0] enab_head, pl_head, ps_head;
  logic             enab_empty, enab_full, pl_empty, pl_full, ps_empty, ps_full;
  logic             alloc;

  logic [FP_W-1:0]  fp_tab [NUM_CTX];
  logic [IP_W-1:0]  ip_tab [NUM_CTX];

  logic             mp_busy_q, mp_start_q;
  mp_kind_e         mp_kind_q;
  logic [CTX_W-1:0] mp_ctx_q;
  logic             take_post, take_pre, mp_fin, pre_fin, post_fin;

  logic             ex_busy_q, ex_start_q;
  logic [CTX_W-1:0] ex_ctx_q;
  logic             ex_take, ex_fin;

  logic             to_ex_v, to_mp_v;
  logic [CTX_W-1:0] to_ex_ctx, to_mp_ctx;
  logic             ffree_q;
  logic [FP_W-1:0]  ffree_fp_q;
  logic             unused_full;

  assign wait_push   = thr_valid_i && !wait_full;
  assign thr_ready_o = !wait_full;
  assign alloc       = !wait_empty && !pool_empty && !enab_full;

  assign take_post = !mp_busy_q && !ps_empty;
  assign take_pre  = !mp_busy_q && ps_empty && !enab_empty;
  assign mp_fin    = mp_done_i && mp_busy_q;
  assign pre_fin   = mp_fin && (mp_kind_q == MP_PRELOAD);
  assign post_fin  = mp_fin && (mp_kind_q == MP_POSTSTORE);
  assign ex_take   = !ex_busy_q && !pl_empty;
  assign ex_fin    = ex_done_i && ex_busy_q;

  assign unused_full = ^{pool_full, pl_full, ps_full};

  thr_fifo #(.WIDTH(ARR_W), .DEPTH(WAIT_DEPTH), .PRELOAD(1'b0)) i_wait_q (
    .clk_i, .rst_ni,
    .push_i(wait_push), .data_i({thr_fp_i, thr_ip_i}),
    .pop_i(alloc), .data_o(wait_head),
    .empty_o(wait_empty), .full_o(wait_full)
  );

  thr_fifo #(.WIDTH(CTX_W), .DEPTH(NUM_CTX), .PRELOAD(1'b1)) i_ctx_ring (
    .clk_i, .rst_ni,
    .push_i(post_fin), .data_i(mp_ctx_q),
    .pop_i(alloc), .data_o(pool_head),
    .empty_o(pool_empty), .full_o(pool_full)
  );

  thr_fifo #(.WIDTH(CTX_W), .DEPTH(NUM_CTX), .PRELOAD(1'b0)) i_enab_q (
    .clk_i, .rst_ni,
    .push_i(alloc), .data_i(pool_head),
    .pop_i(take_pre), .data_o(enab_head),
    .empty_o(enab_empty), .full_o(enab_full)
  );

  thr_fork_line #(.LAT(FORK_LAT), .WIDTH(CTX_W)) i_fork_ex (
    .clk_i, .rst_ni,
    .in_valid_i(pre_fin), .in_data_i(mp_ctx_q),
    .out_valid_o(to_ex_v), .out_data_o(to_ex_ctx)
  );

  thr_fifo #(.WIDTH(CTX_W), .DEPTH(NUM_CTX), .PRELOAD(1'b0)) i_pl_q (
    .clk_i, .rst_ni,
    .push_i(to_ex_v), .data_i(to_ex_ctx),
    .pop_i(ex_take), .data_o(pl_head),
    .empty_o(pl_empty), .full_o(pl_full)
  );

  thr_fork_line #(.LAT(FORK_LAT), .WIDTH(CTX_W)) i_fork_mp (
    .clk_i, .rst_ni,
    .in_valid_i(ex_fin), .in_data_i(ex_ctx_q),
    .out_valid_o(to_mp_v), .out_data_o(to_mp_ctx)
  );

  thr_fifo #(.WIDTH(CTX_W), .DEPTH(NUM_CTX), .PRELOAD(1'b0)) i_ps_q (
    .clk_i, .rst_ni,
    .push_i(to_mp_v), .data_i(to_mp_ctx),
    .pop_i(take_post), .data_o(ps_head),
    .empty_o(ps_empty), .full_o(ps_full)
  );

  // context table: frame index and current phase address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CTX; i++) begin
        fp_tab[i] <= '0;
        ip_tab[i] <= '0;
      end
    end else begin
      if (alloc) begin
        fp_tab[pool_head] <= wait_head[IP_W +: FP_W];
        ip_tab[pool_head] <= wait_head[IP_W-1:0];
      end
      if (pre_fin) ip_tab[mp_ctx_q] <= mp_next_ip_i;
      if (ex_fin)  ip_tab[ex_ctx_q] <= ex_next_ip_i;
    end
  end

  // memory-access pipeline: post-store wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp_busy_q  <= 1'b0;
      mp_start_q <= 1'b0;
      mp_kind_q  <= MP_PRELOAD;
      mp_ctx_q   <= '0;
    end else begin
      mp_start_q <= take_post || take_pre;
      if (take_post) begin
        mp_busy_q <= 1'b1;
        mp_kind_q <= MP_POSTSTORE;
        mp_ctx_q  <= ps_head;
      end else if (take_pre) begin
        mp_busy_q <= 1'b1;
        mp_kind_q <= MP_PRELOAD;
        mp_ctx_q  <= enab_head;
      end else if (mp_fin) begin
        mp_busy_q <= 1'b0;
      end
    end
  end

  // execution pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_busy_q  <= 1'b0;
      ex_start_q <= 1'b0;
      ex_ctx_q   <= '0;
    end else begin
      ex_start_q <= ex_take;
      if (ex_take) begin
        ex_busy_q <= 1'b1;
        ex_ctx_q  <= pl_head;
      end else if (ex_fin) begin
        ex_busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ffree_q    <= 1'b0;
      ffree_fp_q <= '0;
    end else begin
      ffree_q    <= post_fin;
      ffree_fp_q <= fp_tab[mp_ctx_q];
    end
  end

  assign mp_start_o    = mp_start_q;
  assign mp_store_o    = (mp_kind_q == MP_POSTSTORE);
  assign mp_ctx_o      = mp_ctx_q;
  assign mp_fp_o       = fp_tab[mp_ctx_q];
  assign mp_ip_o       = ip_tab[mp_ctx_q];
  assign ex_start_o    = ex_start_q;
  assign ex_ctx_o      = ex_ctx_q;
  assign ex_ip_o       = ip_tab[ex_ctx_q];
  assign ffree_valid_o = ffree_q;
  assign ffree_fp_o    = ffree_fp_q;
endmodule

// File: rtl/thr_sched_chk.sv
module thr_sched_chk #(
  parameter int CTX_W = 2,
  parameter int IP_W  = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mp_start_o,
  input logic             mp_store_o,
  input logic [CTX_W-1:0] mp_ctx_o,
  input logic [IP_W-1:0]  mp_ip_o,
  input logic             mp_done_i,
  input logic             ex_start_o,
  input logic             ex_done_i,
  input logic             ffree_valid_o
);
  logic mp_pend, ex_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp_pend <= 1'b0;
      ex_pend <= 1'b0;
    end else begin
      if (mp_start_o)     mp_pend <= 1'b1;
      else if (mp_done_i) mp_pend <= 1'b0;
      if (ex_start_o)     ex_pend <= 1'b1;
      else if (ex_done_i) ex_pend <= 1'b0;
    end
  end

  AST_MP_ONE_THREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mp_start_o |-> !mp_pend);  // R8
  AST_EX_ONE_THREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_start_o |-> !ex_pend);  // R8
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mp_start_o || ex_start_o) |=> !(mp_start_o && $past(mp_start_o)) && !(ex_start_o && $past(ex_start_o)));  // R8
  AST_FREE_AFTER_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ffree_valid_o |-> $past(mp_done_i && mp_store_o && mp_pend));  // R9
  AST_MP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mp_pend && !mp_done_i) |=> ($stable(mp_ctx_o) && $stable(mp_ip_o) && $stable(mp_store_o)));  // R10
endmodule

bind thr_sched thr_sched_chk #(.CTX_W(CTX_W), .IP_W(IP_W)) i_thr_sched_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mp_start_o(mp_start_o), .mp_store_o(mp_store_o), .mp_ctx_o(mp_ctx_o),
  .mp_ip_o(mp_ip_o), .mp_done_i(mp_done_i),
  .ex_start_o(ex_start_o), .ex_done_i(ex_done_i),
  .ffree_valid_o(ffree_valid_o)
);

// File: tb/test_thr_sched.sv
module test_thr_sched;
  localparam int NUM_CTX = 4;
  localparam int FP_W = 8;
  localparam int IP_W = 12;
  localparam int WAIT_DEPTH = 4;
  localparam int FORK_LAT = 4;
  localparam int CTX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_valid_i = 1'b0;
  logic [FP_W-1:0] thr_fp_i = '0;
  logic [IP_W-1:0] thr_ip_i = '0;
  logic thr_ready_o;
  logic mp_start_o, mp_store_o;
  logic [CTX_W-1:0] mp_ctx_o;
  logic [FP_W-1:0] mp_fp_o;
  logic [IP_W-1:0] mp_ip_o;
  logic mp_done_i = 1'b0;
  logic [IP_W-1:0] mp_next_ip_i = '0;
  logic ex_start_o;
  logic [CTX_W-1:0] ex_ctx_o;
  logic [IP_W-1:0] ex_ip_o;
  logic ex_done_i = 1'b0;
  logic [IP_W-1:0] ex_next_ip_i = '0;
  logic ffree_valid_o;
  logic [FP_W-1:0] ffree_fp_o;

  thr_sched #(.NUM_CTX(NUM_CTX), .FP_W(FP_W), .IP_W(IP_W),
              .WAIT_DEPTH(WAIT_DEPTH), .FORK_LAT(FORK_LAT)) i_thr_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .thr_valid_i, .thr_fp_i, .thr_ip_i, .thr_ready_o,
    .mp_start_o, .mp_store_o, .mp_ctx_o, .mp_fp_o, .mp_ip_o, .mp_done_i, .mp_next_ip_i,
    .ex_start_o, .ex_ctx_o, .ex_ip_o, .ex_done_i, .ex_next_ip_i,
    .ffree_valid_o, .ffree_fp_o
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [FP_W-1:0] q_fp[$];
  logic [IP_W-1:0] q_ip[$];
  logic [FP_W-1:0] q_free[$];
  int pool_m[$] = '{0, 1, 2, 3};
  int q_ex[$], q_post[$], exd_edge[$];
  logic [FP_W-1:0] t_fp[NUM_CTX];
  logic [IP_W-1:0] t_ip[NUM_CTX];
  int mp_lat = 3, ex_lat = 3, mp_wait = 0, ex_wait = 0;
  bit pause = 0, timing_chk = 0, mp_busy_tb = 0, ex_busy_tb = 0;
  int pre_done_edge, ex_done_edge, post_done_edge, accept_edge, frees_seen = 0;
  logic [CTX_W-1:0] cap_ctx;
  logic [IP_W-1:0] cap_ip;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc = cyc + 1;

  // scoreboard monitor and pipeline responders
  always @(negedge clk) begin
    if (rst_n) begin
      if (mp_start_o) begin
        chk(!mp_busy_tb, "R8", "mp start while busy", 1, 0);
        mp_busy_tb = 1;
        cap_ctx = mp_ctx_o;
        cap_ip = mp_ip_o;
        if (!mp_store_o) begin
          if (exd_edge.size() > 0)
            chk(cyc < exd_edge[0] + FORK_LAT + 1, "R7", "preload passed pending post-store",
                cyc, exd_edge[0] + FORK_LAT + 1);
          if (q_fp.size() == 0) chk(0, "R4", "unexpected preload", 1, 0);
          else begin
            automatic logic [FP_W-1:0] efp = q_fp.pop_front();
            automatic logic [IP_W-1:0] eip = q_ip.pop_front();
            automatic int ectx = pool_m.pop_front();
            chk(mp_fp_o == efp, "R4", "preload fp", mp_fp_o, efp);
            chk(mp_ip_o == eip, "R4", "preload ip", mp_ip_o, eip);
            chk(int'(mp_ctx_o) == ectx, "R2", "context order", mp_ctx_o, ectx);
            t_fp[ectx] = efp;
            t_ip[ectx] = eip;
            if (timing_chk) chk(cyc == accept_edge + 2, "R4", "preload start edge", cyc, accept_edge + 2);
          end
        end else begin
          if (q_post.size() == 0) chk(0, "R6", "unexpected post-store", 1, 0);
          else begin
            automatic int ectx = q_post.pop_front();
            chk(int'(mp_ctx_o) == ectx, "R6", "post-store ctx", mp_ctx_o, ectx);
            chk(mp_ip_o == t_ip[ectx] + 12'h30, "R6", "post-store ip", mp_ip_o, t_ip[ectx] + 12'h30);
            if (timing_chk) chk(cyc == ex_done_edge + FORK_LAT + 1, "R6", "post-store start edge",
                                cyc, ex_done_edge + FORK_LAT + 1);
            if (exd_edge.size() > 0) void'(exd_edge.pop_front());
            q_free.push_back(t_fp[ectx]);
          end
        end
      end else if (mp_busy_tb) begin
        chk(mp_ctx_o == cap_ctx && mp_ip_o == cap_ip, "R10", "mp outputs held", mp_ip_o, cap_ip);
      end
      if (ex_start_o) begin
        chk(!ex_busy_tb, "R8", "ex start while busy", 1, 0);
        ex_busy_tb = 1;
        if (q_ex.size() == 0) chk(0, "R5", "unexpected ex start", 1, 0);
        else begin
          automatic int ectx = q_ex.pop_front();
          chk(int'(ex_ctx_o) == ectx, "R5", "ex ctx", ex_ctx_o, ectx);
          chk(ex_ip_o == t_ip[ectx] + 12'h10, "R5", "ex ip", ex_ip_o, t_ip[ectx] + 12'h10);
          if (timing_chk) chk(cyc == pre_done_edge + FORK_LAT + 1, "R5", "ex start edge",
                              cyc, pre_done_edge + FORK_LAT + 1);
          q_post.push_back(ectx);
        end
      end
      if (ffree_valid_o) begin
        frees_seen++;
        if (q_free.size() == 0) chk(0, "R9", "unexpected free", ffree_fp_o, 0);
        else begin
          automatic logic [FP_W-1:0] efp = q_free.pop_front();
          chk(ffree_fp_o == efp, "R9", "free fp", ffree_fp_o, efp);
          if (timing_chk) chk(cyc == post_done_edge, "R9", "free edge", cyc, post_done_edge);
        end
      end
      // responders
      mp_done_i = 1'b0;
      ex_done_i = 1'b0;
      if (mp_start_o) mp_wait = mp_lat;
      else if (mp_busy_tb && !pause && mp_wait > 0) begin
        mp_wait--;
        if (mp_wait == 0) begin
          mp_done_i = 1'b1;
          mp_busy_tb = 0;
          if (mp_store_o) begin
            mp_next_ip_i = '0;
            post_done_edge = cyc + 1;
            pool_m.push_back(int'(mp_ctx_o));
          end else begin
            mp_next_ip_i = mp_ip_o + 12'h10;
            pre_done_edge = cyc + 1;
            q_ex.push_back(int'(mp_ctx_o));
          end
        end
      end
      if (ex_start_o) ex_wait = ex_lat;
      else if (ex_busy_tb && !pause && ex_wait > 0) begin
        ex_wait--;
        if (ex_wait == 0) begin
          ex_done_i = 1'b1;
          ex_busy_tb = 0;
          ex_next_ip_i = ex_ip_o + 12'h20;
          ex_done_edge = cyc + 1;
          exd_edge.push_back(cyc + 1);
        end
      end
    end
  end

  task automatic send(input logic [FP_W-1:0] fp, input logic [IP_W-1:0] ip, output bit acc);
    thr_valid_i = 1'b1;
    thr_fp_i = fp;
    thr_ip_i = ip;
    acc = thr_ready_o;
    if (acc) begin
      q_fp.push_back(fp);
      q_ip.push_back(ip);
      accept_edge = cyc + 1;
    end
    @(negedge clk);
    thr_valid_i = 1'b0;
  endtask

  task automatic wait_frees(input int n);
    while (frees_seen < n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mp_start_o == 0, "R1", "mp_start after reset", mp_start_o, 0);
    chk(ex_start_o == 0, "R1", "ex_start after reset", ex_start_o, 0);
    chk(ffree_valid_o == 0, "R1", "ffree after reset", ffree_valid_o, 0);
    chk(thr_ready_o == 1, "R1", "ready after reset", thr_ready_o, 1);

    // single thread with exact timing
    timing_chk = 1;
    send(8'h11, 12'h100, acc);
    chk(acc, "R3", "first accept", acc, 1);
    wait_frees(1);
    timing_chk = 0;

    // six threads: context reuse and post-store priority
    mp_lat = 6;
    ex_lat = 2;
    for (int i = 0; i < 6; i++) begin
      send(8'h20 + 8'(i), 12'h200 + 12'(i * 12'h40), acc);
      chk(acc, "R3", "burst accept", acc, 1);
    end
    wait_frees(7);

    // fill contexts and waiting queue while pipelines are stalled
    pause = 1;
    mp_lat = 2;
    ex_lat = 1;
    for (int i = 0; i < 8; i++) begin
      send(8'h40 + 8'(i), 12'h400 + 12'(i * 12'h40), acc);
      chk(acc, "R3", "fill accept", acc, 1);
    end
    chk(thr_ready_o == 0, "R3", "ready low when full", thr_ready_o, 0);
    send(8'h7f, 12'hf00, acc);
    chk(!acc, "R3", "rejected when full", acc, 0);
    pause = 0;
    wait_frees(15);
    chk(q_fp.size() == 0, "R3", "all arrivals preloaded", q_fp.size(), 0);
    chk(q_free.size() == 0 && q_post.size() == 0 && q_ex.size() == 0, "R9", "all threads retired",
        q_free.size() + q_post.size() + q_ex.size(), 0);
    chk(frees_seen == 15, "R9", "free count", frees_seen, 15);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule